// File: doc/BRIEF.md
# Serial Clock-Chip Register Loader

This block brings an external clock-distribution device out of reset and programs it over a three-wire serial link. The link has a serial clock, an active-low chip enable and a data-out line, plus a data-in line for returned data. A load request first walks the device through a timed power-down and sync sequence. It then sends nine configuration frames taken from one of two parameter tables, picked by a select input.

A verify request reads one device register and checks it. The block sends a read command frame, then clocks in a 32-bit reply. It drops the four address bits of the reply and compares the remaining 28 bits with the expected word from the chosen table. A one-cycle done pulse carries the pass/fail result. Each frame is 32 bits, sent least-significant bit first. The serial clock runs at the system clock divided by a parameter.

Top module: `clkchip_loader`

## Requirements
- R1: A load request drives pd_n low (with cs_n high), waits, raises pd_n, waits, drives sync_n low, waits, raises sync_n, and waits again before the first frame. Each wait lasts at least WAIT_CYCLES system clocks.
- R2: A load sends exactly NREG (9) frames in index order 0..8. Frame k is {table word k (28 bits), k in bits 3:0}. The table is TABLE_A if sel_tbl was 0 at the request and TABLE_B if it was 1.
- R3: Each frame has exactly 32 rising sclk edges with cs_n low throughout, bit 0 first. cs_n returns high between frames.
- R4: mosi never changes in the cycle where sclk rises. Data is set up while sclk is low.
- R5: A verify request runs no reset sequence. Its first frame has bits 7:4 set to vreg, bits 3:0 set to 4'hE, and bits 31:8 zero.
- R6: The second verify frame keeps mosi low and samples sdi, bit 0 first, while sclk is high. pass is 1 only if bits 31:4 of the reply equal table word vreg of the table that sel_tbl chose at the request.
- R7: A verify of index 9..15 reports pass = 0.
- R8: While idle: cs_n, pd_n and sync_n are high, and sclk is low.
- R9: busy rises in the cycle after a request and stays high until the last frame ends. Requests seen while busy are ignored.
- R10: done is a one-cycle pulse at the end of each verify, with pass valid in that cycle. A load never raises done.
- R11: Each high phase of sclk lasts exactly DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request (reset sequence plus table download) |
| verify | input | 1 | Readback-and-compare request |
| sel_tbl | input | 1 | Table choice: 0 = TABLE_A, 1 = TABLE_B |
| vreg | input | 4 | Register index for a verify |
| sdi | input | 1 | Serial data returned by the device |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip enable |
| mosi | output | 1 | Serial data to the device |
| pd_n | output | 1 | Active-low power-down |
| sync_n | output | 1 | Active-low sync |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of a verify |
| pass | output | 1 | Verify result, valid with done |

## Verification
The bench includes a behavioural model of the device. The model stores written frames by their address nibble and answers read commands. Loads are run with both table selections. Because each table's frames differ per index, this reveals a wrong table, a wrong index order or bit reversal. Verifies run with a random index and a random table choice; entries 7 and 8 are the same in both tables, so a match across tables is told apart from a wrong compare. A corrupted device reply, out-of-range indices and requests issued mid-load exercise the fail path and the ignore rule.

// File: rtl/clkchip_loader.sv
module clkchip_loader #(
  parameter int WAIT_CYCLES = 64,
  parameter int DIV = 4,
  parameter int NREG = 9,
  parameter logic [NREG*28-1:0] TABLE_A = {28'h0001800, 28'h1400000, 28'h1010000,
    28'h00009D4, 28'h1540000, 28'h1540001, 28'h1540002, 28'h1540003, 28'h1540004},
  parameter logic [NREG*28-1:0] TABLE_B = {28'h0001800, 28'h1400000, 28'h1020000,
    28'h000019B, 28'h1154020, 28'h1154021, 28'h1154022, 28'h1154023, 28'h1154024}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       verify,
  input  logic       sel_tbl,
  input  logic [3:0] vreg,
  input  logic       sdi,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  output logic       pd_n,
  output logic       sync_n,
  output logic       busy,
  output logic       done,
  output logic       pass
);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam int DW = $clog2(DIV) + 1;

  typedef enum logic [2:0] {S_IDLE, S_PD, S_UP, S_SLO, S_SHI, S_SHIFT, S_GAP} st_t;

  st_t         st;
  logic        is_rd, rd2, sel_q, ph;
  logic [3:0]  fidx;
  logic [4:0]  bitn;
  logic [31:0] sr, rx;
  logic [WW-1:0] wcnt;
  logic [DW-1:0] dcnt;

  function automatic logic [27:0] word(input logic s, input logic [3:0] i);
    word = '0;
    if (int'(i) < NREG) word = s ? TABLE_B[int'(i)*28 +: 28] : TABLE_A[int'(i)*28 +: 28];
  endfunction

  wire in_ser    = (st == S_SHIFT) || (st == S_GAP);
  wire tick      = in_ser && (dcnt == DW'(DIV - 1));
  wire wait_done = (wcnt == WW'(WAIT_CYCLES - 1));
  wire [3:0] fnext = fidx + 4'd1;

  assign busy = (st != S_IDLE);
  assign mosi = sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; is_rd <= 1'b0; rd2 <= 1'b0; sel_q <= 1'b0; ph <= 1'b0;
      fidx <= '0; bitn <= '0; sr <= '0; rx <= '0; wcnt <= '0; dcnt <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; pd_n <= 1'b1; sync_n <= 1'b1;
      done <= 1'b0; pass <= 1'b0;
    end else begin
      done <= 1'b0;
      dcnt <= (in_ser && !tick) ? dcnt + DW'(1) : '0;
      wcnt <= (st inside {S_PD, S_UP, S_SLO, S_SHI} && !wait_done) ? wcnt + WW'(1) : '0;
      case (st)
        S_IDLE: begin
          sel_q <= sel_tbl;
          if (start) begin
            is_rd <= 1'b0; fidx <= '0; pd_n <= 1'b0; cs_n <= 1'b1; st <= S_PD;
          end else if (verify) begin
            is_rd <= 1'b1; rd2 <= 1'b0; fidx <= vreg;
            sr <= {24'd0, vreg, 4'hE}; cs_n <= 1'b0; bitn <= '0; ph <= 1'b0; st <= S_SHIFT;
          end
        end
        S_PD:  if (wait_done) begin pd_n <= 1'b1;   st <= S_UP;  end
        S_UP:  if (wait_done) begin sync_n <= 1'b0; st <= S_SLO; end
        S_SLO: if (wait_done) begin sync_n <= 1'b1; st <= S_SHI; end
        S_SHI: if (wait_done) begin
          sr <= {word(sel_q, 4'd0), 4'd0}; cs_n <= 1'b0; bitn <= '0; ph <= 1'b0; st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!ph) begin
            sclk <= 1'b1; ph <= 1'b1;
          end else begin
            sclk <= 1'b0; ph <= 1'b0;
            rx <= {sdi, rx[31:1]};
            sr <= sr >> 1;
            bitn <= bitn + 5'd1;
            if (bitn == 5'd31) begin cs_n <= 1'b1; st <= S_GAP; end
          end
        end
        S_GAP: if (tick) begin
          if (is_rd) begin
            if (!rd2) begin
              rd2 <= 1'b1; sr <= '0; cs_n <= 1'b0; bitn <= '0; st <= S_SHIFT;
            end else begin
              done <= 1'b1;
              pass <= (int'(fidx) < NREG) && (rx[31:4] == word(sel_q, fidx));
              st <= S_IDLE;
            end
          end else if (int'(fidx) == NREG - 1) begin
            st <= S_IDLE;
          end else begin
            fidx <= fnext; sr <= {word(sel_q, fnext), fnext};
            cs_n <= 1'b0; bitn <= '0; st <= S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R4
  AST_CLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R3
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && pd_n && sync_n && !sclk)); // R8
  AST_READ_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && rd2 && st == S_SHIFT) |-> !mosi); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R9
endmodule

// File: tb/clkchip_loader_tb.sv
`timescale 1ns/1ps
module clkchip_loader_tb;
  localparam int W = 20;
  localparam int D = 2;
  localparam logic [251:0] TA = {28'h0001800, 28'h1400000, 28'h1010000,
    28'h00009D4, 28'h1540000, 28'h1540001, 28'h1540002, 28'h1540003, 28'h1540004};
  localparam logic [251:0] TB = {28'h0001800, 28'h1400000, 28'h1020000,
    28'h000019B, 28'h1154020, 28'h1154021, 28'h1154022, 28'h1154023, 28'h1154024};

  logic clk = 0, rst_n = 0, start = 0, verify = 0, sel_tbl = 0, sdi = 0;
  logic [3:0] vreg = 0;
  logic sclk, cs_n, mosi, pd_n, sync_n, busy, done, pass;

  clkchip_loader #(.WAIT_CYCLES(W), .DIV(D), .NREG(9), .TABLE_A(TA), .TABLE_B(TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify(verify), .sel_tbl(sel_tbl),
    .vreg(vreg), .sdi(sdi), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .pd_n(pd_n),
    .sync_n(sync_n), .busy(busy), .done(done), .pass(pass));

  always #2 clk = ~clk;

  int errs = 0, checks = 0, ndone = 0, npd = 0, nfr = 0, bcnt = 0, rcnt = 0, hph_err = 0;
  logic [31:0] flog [0:15];
  int fbits [0:15];
  logic [31:0] shreg, resp;
  logic [31:0] dev_regs [0:15];
  logic rd_pend = 0, corrupt = 0, cs_at_pdl = 0, cs_seen = 0;
  logic [3:0] cidx = 0;
  time t_pdl, t_pdh, t_syl, t_syh, t_cs0, t_rise;

  function automatic logic [27:0] tw(input logic s, input int i);
    return s ? TB[i*28 +: 28] : TA[i*28 +: 28];
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial for (int i = 0; i < 16; i++) dev_regs[i] = '0;

  always @(posedge clk) if (done) ndone++;
  always @(negedge pd_n) begin t_pdl = $time; cs_at_pdl = cs_n; npd++; end
  always @(posedge pd_n) t_pdh = $time;
  always @(negedge sync_n) t_syl = $time;
  always @(posedge sync_n) t_syh = $time;
  always @(negedge cs_n) begin
    if (!cs_seen) begin t_cs0 = $time; cs_seen = 1; end
    bcnt = 0; rcnt = 0; shreg = '0;
  end
  always @(posedge sclk) begin
    t_rise = $time;
    if (!cs_n && bcnt < 32) shreg[bcnt] = mosi;
    bcnt++;
  end
  always @(negedge sclk) begin
    if (($time - t_rise) != D * 4) hph_err++;
    #1 rcnt++;
  end
  always @(posedge cs_n) begin
    if (nfr < 16) begin flog[nfr] = shreg; fbits[nfr] = bcnt; end
    nfr++;
    if (rd_pend) rd_pend = 0;
    else if (shreg[3:0] == 4'hE) begin
      rd_pend = 1;
      resp = dev_regs[shreg[7:4]] ^ ((corrupt && shreg[7:4] == cidx) ? 32'h100 : 32'h0);
    end else dev_regs[shreg[3:0]] = shreg;
  end
  always_comb sdi = resp[rcnt[4:0]];

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  logic loaded_sel = 0;

  task automatic do_load(input logic s, input bit poke);
    int nd0, np0;
    nfr = 0; cs_seen = 0; nd0 = ndone; np0 = npd; hph_err = 0;
    @(negedge clk); start = 1; sel_tbl = s;
    @(negedge clk); start = 0; sel_tbl = ~s;
    chk(busy === 1'b1, "R9 busy after load request", busy, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      verify = 1; start = 1; vreg = 4'd2;
      @(negedge clk); verify = 0; start = 0;
    end
    wait_idle();
    loaded_sel = s;
    chk(npd == np0 + 1 && cs_at_pdl === 1'b1, "R1 power-down with cs_n high", cs_at_pdl, 1);
    chk(t_pdl < t_pdh && t_pdh < t_syl && t_syl < t_syh && t_syh < t_cs0, "R1 reset order", 0, 0);
    chk((t_pdh - t_pdl) >= W*4 && (t_syl - t_pdh) >= W*4 && (t_syh - t_syl) >= W*4
        && (t_cs0 - t_syh) >= W*4, "R1 wait lengths", 32'(t_cs0 - t_syh), W*4);
    chk(nfr == 9, "R2 frame count", nfr, 9);
    for (int k = 0; k < 9 && k < nfr; k++) begin
      chk(flog[k] === {tw(s, k), 4'(k)}, "R2 frame content", flog[k], {tw(s, k), 4'(k)});
      chk(fbits[k] == 32, "R3 rising edges per frame", fbits[k], 32);
    end
    chk(ndone == nd0, "R10 no done on load", ndone, nd0);
    chk(hph_err == 0, "R11 sclk high phase", hph_err, 0);
    chk(cs_n && pd_n && sync_n && !sclk, "R8 idle levels after load", {cs_n, pd_n, sync_n, sclk}, 4'b1110);
  endtask

  task automatic do_verify(input logic s, input logic [3:0] idx);
    logic expv;
    int np0;
    np0 = npd; nfr = 0;
    expv = (idx <= 8) && (tw(s, idx) == tw(loaded_sel, idx)) && !(corrupt && idx == cidx);
    @(negedge clk); verify = 1; sel_tbl = s; vreg = idx;
    @(negedge clk); verify = 0; sel_tbl = ~s; vreg = ~idx;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    chk(done === 1'b1, "R10 done seen", done, 1);
    chk(pass === expv, (idx > 8) ? "R7 out-of-range index" : "R6 compare result", pass, expv);
    chk(busy === 1'b0, "R9 busy low at done", busy, 0);
    chk(nfr == 2 && flog[0] === {24'd0, idx, 4'hE}, "R5 read command frame", flog[0], {24'd0, idx, 4'hE});
    chk(npd == np0, "R5 no reset sequence on verify", npd, np0);
    chk(flog[1] === 32'h0, "R6 mosi low during reply", flog[1], 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && pd_n && sync_n && !sclk && !busy && !done, "R8 reset state",
        {cs_n, pd_n, sync_n, sclk, busy, done}, 6'b111000);
    for (int n = 0; n < 6; n++) begin
      logic s;
      s = (n < 2) ? n[0] : 1'($urandom % 2);
      do_load(s, 0);
      for (int v = 0; v < 4; v++) do_verify(1'($urandom % 2), 4'($urandom % 9));
    end
    do_load(0, 0);
    do_verify(1, 4'd7);
    do_verify(1, 4'd8);
    do_verify(1, 4'd0);
    do_verify(0, 4'd0);
    corrupt = 1; cidx = 4'd3;
    do_verify(0, 4'd3);
    do_verify(0, 4'd4);
    corrupt = 0;
    do_verify(0, 4'd9);
    do_verify(0, 4'd15);
    do_load(1, 1);
    do_verify(1, 4'd5);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule